// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block sits between the receive side of an Ethernet MAC and system memory. It takes a byte stream whose bytes may carry an error flag and holds each frame in a local store-and-forward buffer until its last byte has arrived. It then decides whether the frame is worth a descriptor. Runt frames and frames the MAC flagged as bad are discarded unless their forwarding control is set. A frame that is kept is copied into the buffer of the current descriptor, and a status word holding the length and the error flags is written back with the ownership bit cleared. The engine then moves on to the descriptor named by the next pointer.

Descriptors form a linked ring in a word-addressed memory. Each descriptor has four words at consecutive word addresses: status (ownership in bit 31), control with the usable buffer size in bits 13:0, the buffer byte address, and the next-descriptor byte address. Software loads the ring's first descriptor address with a start pulse and sets the two forwarding controls. A frame that finds the current descriptor owned by software is lost and counted.

Top module: `rxwb_engine`

## Requirements
- R1: While reset is held and after it until the start pulse, rx_ready is 0, mem_req is 0 and ovf_count is 0.
- R2: A cfg_start pulse while idle loads the first descriptor from cfg_base (byte address, word aligned) and raises rx_ready. While a frame is being received (rx_ready high) the memory port stays idle, so no frame data reaches memory before its last byte is accepted.
- R3: Byte i of a kept frame is written to the descriptor's buffer at word (buffer address / 4) + i/4, bits 8*(i%4)+7 to 8*(i%4). Bytes of the final word beyond the written length are undefined.
- R4: The written-back status word has bit 31 (own) = 0, bit 30 = 0, the received length in bytes in bits 29:16 and the flags of R6 to R8. All other bits are 0, and a clean frame therefore has status = length << 16.
- R5: A frame shorter than 64 bytes is a runt. With cfg_fwd_runt = 0 it is discarded without touching memory, and the next frame uses the same descriptor. A 64-byte frame is not a runt.
- R6: A runt forwarded with cfg_fwd_runt = 1 is written with status bits 11 and 0 set.
- R7: A frame with rx_err high on any accepted byte is discarded without touching memory when cfg_fwd_err = 0. When cfg_fwd_err = 1 it is written with status bits 1 and 0 set.
- R8: A kept frame longer than the descriptor's size field writes only ceil(size/4) buffer words and leaves later words unchanged. Its status sets bits 7 and 0 and still reports the full received length.
- R9: The descriptor words are at word offsets 0 (status), 1 (size), 2 (buffer address) and 3 (next address). After a write-back the engine follows the next address, so a ring wraps to its first descriptor.
- R10: If the current descriptor's own bit is 0 when a kept frame ends, the frame is discarded, ovf_count increments by one and the descriptor is left untouched. The engine stays on that descriptor and reads it again at the end of the next frame.
- R11: After the last byte of a frame is accepted, rx_ready drops in the next cycle and stays low until that frame has been fully handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Pulse: begin at cfg_base (honoured while idle) |
| cfg_base | input | 32 | Byte address of the first descriptor |
| cfg_fwd_runt | input | 1 | 1 keeps runt frames |
| cfg_fwd_err | input | 1 | 1 keeps frames flagged bad by the MAC |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_err | input | 1 | MAC error flag for this byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_ready | output | 1 | Engine accepts stream bytes |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read (data next cycle) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read request |
| ovf_count | output | CNT_W | Frames lost for lack of an owned descriptor |

## Verification
The bench uses the defaults: ADDR_W = 10 (a 1024-word memory), BUF_WORDS = 64 (256-byte frame store), RUNT_BYTES = 64 and CNT_W = 16. It builds a four-descriptor ring with a 200-byte size field. That makes every decision reachable with short frames: runts just below and at the 64-byte limit, frames that overrun the 200-byte descriptor while still fitting the 256-byte store, and ring wrap after four write-backs. Random lengths up to 230 bytes, with random error placement and forwarding settings, exercise all the drop and keep combinations.

// File: rtl/rxwb_pkg.sv
// Shared constants and state encoding for the receive write-back engine.
package rxwb_pkg;
    localparam int LEN_W       = 14;   // width of the length field in the status word
    localparam int ST_OWN      = 31;   // ownership bit
    localparam int ST_LEN_LSB  = 16;   // length field position
    localparam int FL_SUMMARY  = 0;    // any error
    localparam int FL_MAC_ERR  = 1;    // MAC flagged a byte
    localparam int FL_TOO_LONG = 7;    // frame exceeded descriptor size
    localparam int FL_RUNT     = 11;   // frame below runt limit
    localparam logic [31:0] ERR_BITS  = 32'h4000_68DB;
    localparam logic [31:0] LEN_FIELD = 32'h3FFF_0000;

    typedef enum logic [2:0] {
        S_IDLE, S_RECV, S_EVAL, S_FETCH, S_CHECK, S_WRITE, S_STATUS
    } rxwb_state_e;
endpackage

// File: rtl/rxwb_frame_buf.sv
// Store-and-forward frame buffer: packs stream bytes little-endian into
// words, counts the frame length (saturating) and remembers any error flag.
// Assumes clear is never raised in a cycle that pushes a byte.
module rxwb_frame_buf #(
    parameter int BUF_WORDS = 64,
    parameter int LEN_W     = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [7:0]                   push_byte,
    input  logic                         push_err,
    input  logic [$clog2(BUF_WORDS)-1:0] rd_idx,
    output logic [31:0]                  rd_word,
    output logic [LEN_W-1:0]             len,
    output logic                         err_seen
);
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int CAP_BYTES = BUF_WORDS * 4;

    logic [31:0]      store [BUF_WORDS];
    logic [LEN_W-1:0] len_q;
    logic             err_q;
    logic [IDX_W-1:0] wr_idx;
    logic [1:0]       wr_lane;

    assign wr_idx  = len_q[IDX_W+1:2];
    assign wr_lane = len_q[1:0];

    // Track length and sticky error of the frame being collected.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            len_q <= '0;
            err_q <= 1'b0;
        end else if (push) begin
            if (len_q != '1) len_q <= len_q + 1'b1;
            err_q <= err_q | push_err;
        end
    end

    // Place each byte in its lane while the store has room.
    always_ff @(posedge clk) begin
        if (push && (int'(len_q) < CAP_BYTES))
            store[wr_idx][{wr_lane, 3'b000} +: 8] <= push_byte;
    end

    assign rd_word  = store[rd_idx];
    assign len      = len_q;
    assign err_seen = err_q;
endmodule

// File: rtl/rxwb_classify.sv
// Frame classification: decides drop versus keep from the forwarding
// controls, builds the status word and the number of buffer words to write.
// Assumes the size field does not exceed the buffer store capacity.
module rxwb_classify #(
    parameter int BUF_WORDS  = 64,
    parameter int RUNT_BYTES = 64,
    parameter int LEN_W      = 14
) (
    input  logic [LEN_W-1:0]             len,
    input  logic                         mac_err,
    input  logic [LEN_W-1:0]             size,
    input  logic                         fwd_runt,
    input  logic                         fwd_err,
    output logic                         drop,
    output logic [31:0]                  status,
    output logic [$clog2(BUF_WORDS):0]   nwords
);
    import rxwb_pkg::*;
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int CAP_BYTES = BUF_WORDS * 4;

    logic             is_runt;
    logic             too_long;
    logic [LEN_W-1:0] eff;

    // Classify the frame and derive the write-back words.
    always_comb begin
        is_runt  = int'(len) < RUNT_BYTES;
        too_long = len > size;
        drop     = (is_runt && !fwd_runt) || (mac_err && !fwd_err);
        status                           = '0;
        status[ST_LEN_LSB +: LEN_W]      = len;
        status[FL_RUNT]                  = is_runt;
        status[FL_TOO_LONG]              = too_long;
        status[FL_MAC_ERR]               = mac_err;
        status[FL_SUMMARY]               = is_runt | too_long | mac_err;
        eff = too_long ? size : len;
        if (int'(eff) > CAP_BYTES) eff = LEN_W'(CAP_BYTES);
        nwords = (IDX_W+1)'((int'(eff) + 3) >> 2);
    end
endmodule

// File: rtl/rxwb_engine.sv
// Receive descriptor write-back engine. Collects a whole frame, then reads
// the current descriptor, copies the frame into its buffer, writes back the
// status with ownership released and follows the next pointer.
// Assumes a memory with one-cycle read latency that accepts every request.
module rxwb_engine #(
    parameter int ADDR_W     = 10,
    parameter int BUF_WORDS  = 64,
    parameter int RUNT_BYTES = 64,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [31:0]       cfg_base,
    input  logic              cfg_fwd_runt,
    input  logic              cfg_fwd_err,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_err,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [CNT_W-1:0]  ovf_count
);
    import rxwb_pkg::*;
    localparam int IDX_W = $clog2(BUF_WORDS);
    localparam int WC_W  = IDX_W + 1;

    rxwb_state_e      state;
    logic [ADDR_W-1:0] desc_w, d_buf, d_next;
    logic             d_own;
    logic [LEN_W-1:0] d_size;
    logic [2:0]       fcnt;
    logic [WC_W-1:0]  wcnt;
    logic [CNT_W-1:0] ovf_q;

    logic             push, buf_clear, status_wr;
    logic [31:0]      rd_word, status_word;
    logic [LEN_W-1:0] frame_len;
    logic             frame_err, drop;
    logic [WC_W-1:0]  nwords;
    logic             unused_bits;

    assign rx_ready  = (state == S_RECV);
    assign push      = rx_valid && rx_ready;
    assign status_wr = (state == S_STATUS);
    assign buf_clear = (state == S_EVAL && drop) ||
                       (state == S_CHECK && !d_own) || status_wr;
    assign ovf_count = ovf_q;
    assign unused_bits = ^{mem_rdata, cfg_base};

    rxwb_frame_buf #(.BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .push(push),
        .push_byte(rx_data), .push_err(rx_err), .rd_idx(wcnt[IDX_W-1:0]),
        .rd_word(rd_word), .len(frame_len), .err_seen(frame_err)
    );

    rxwb_classify #(.BUF_WORDS(BUF_WORDS), .RUNT_BYTES(RUNT_BYTES), .LEN_W(LEN_W)) u_cls (
        .len(frame_len), .mac_err(frame_err), .size(d_size),
        .fwd_runt(cfg_fwd_runt), .fwd_err(cfg_fwd_err),
        .drop(drop), .status(status_word), .nwords(nwords)
    );

    // Engine sequencing: receive, classify, fetch, copy, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            desc_w <= '0;
            d_buf  <= '0;
            d_next <= '0;
            d_own  <= 1'b0;
            d_size <= '0;
            fcnt   <= '0;
            wcnt   <= '0;
            ovf_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (cfg_start) begin
                    desc_w <= cfg_base[ADDR_W+1:2];
                    state  <= S_RECV;
                end
                S_RECV: if (push && rx_last) state <= S_EVAL;
                S_EVAL: state <= drop ? S_RECV : S_FETCH;
                S_FETCH: begin
                    case (fcnt)
                        3'd1: d_own  <= mem_rdata[ST_OWN];
                        3'd2: d_size <= mem_rdata[LEN_W-1:0];
                        3'd3: d_buf  <= mem_rdata[ADDR_W+1:2];
                        3'd4: d_next <= mem_rdata[ADDR_W+1:2];
                        default: ;
                    endcase
                    if (fcnt == 3'd4) begin
                        fcnt  <= '0;
                        state <= S_CHECK;
                    end else begin
                        fcnt <= fcnt + 1'b1;
                    end
                end
                S_CHECK: begin
                    wcnt <= '0;
                    if (!d_own) begin
                        ovf_q <= ovf_q + 1'b1;
                        state <= S_RECV;
                    end else if (nwords == '0) begin
                        state <= S_STATUS;
                    end else begin
                        state <= S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (wcnt == nwords - 1'b1) state <= S_STATUS;
                    else                       wcnt  <= wcnt + 1'b1;
                end
                S_STATUS: begin
                    desc_w <= d_next;
                    state  <= S_RECV;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_w;
        mem_wdata = status_word;
        case (state)
            S_FETCH: begin
                mem_req  = (fcnt != 3'd4);
                mem_addr = desc_w + ADDR_W'(fcnt);
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = d_buf + ADDR_W'(wcnt);
                mem_wdata = rd_word;
            end
            S_STATUS: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxwb_engine_chk.sv
// Protocol checker for rxwb_engine, attached by bind below.
module rxwb_engine_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             rx_last,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_wdata,
    input logic [CNT_W-1:0] ovf_count,
    input logic             status_wr
);
    import rxwb_pkg::*;

    AST_QUIET_WHILE_RECV: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !mem_req); // R2

    AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |-> (mem_req && mem_we && !mem_wdata[ST_OWN] &&
                       ((mem_wdata & ~(ERR_BITS | LEN_FIELD)) == 32'h0))); // R4

    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovf_count == $past(ovf_count) ||
                  ovf_count == $past(ovf_count) + 1'b1)); // R10

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_last) |=> !rx_ready); // R11

    AST_WRITE_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R9
endmodule

bind rxwb_engine rxwb_engine_chk #(.CNT_W(CNT_W)) u_rxwb_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_last(rx_last), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .ovf_count(ovf_count), .status_wr(status_wr)
);

// File: tb/test_rxwb_engine.sv
`timescale 1ns/1ps
module test_rxwb_engine;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = 16;
    localparam int NDESC  = 4;
    localparam int SIZE   = 200;
    localparam int BUFB   = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start = 1'b0, cfg_fwd_runt = 1'b0, cfg_fwd_err = 1'b0;
    logic [31:0] cfg_base = '0;
    logic rx_valid = 1'b0, rx_err = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_ready, mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [CNT_W-1:0] ovf_count;

    logic tb_we = 1'b0;
    logic [ADDR_W-1:0] tb_addr = '0;
    logic [31:0] tb_wdata = '0;
    logic [31:0] tb_mem [1024];
    logic [7:0] frame_b [256];

    int n_chk = 0, n_fail = 0, cur = 0;

    always #10 clk = ~clk;

    rxwb_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_rxwb_engine (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_base(cfg_base),
        .cfg_fwd_runt(cfg_fwd_runt), .cfg_fwd_err(cfg_fwd_err),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_last(rx_last),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ovf_count(ovf_count)
    );

    // Memory model: one-cycle read latency, plus a bench write port.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) tb_mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= tb_mem[mem_addr];
        end
        if (tb_we) tb_mem[tb_addr] <= tb_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = ADDR_W'(a); tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic arm(input int k, input bit own);
        wr(k*4 + 0, own ? 32'h8000_0000 : 32'h0);
        wr(k*4 + 1, SIZE);
        wr(k*4 + 2, BUFB + k*256);
        wr(k*4 + 3, ((k + 1) % NDESC) * 16);
    endtask

    function automatic logic [31:0] exp_status(input int len, input bit err, input int size);
        logic [31:0] s = '0;
        bit runt = len < 64;
        bit lng  = len > size;
        s[29:16] = len[13:0];
        s[11] = runt; s[7] = lng; s[1] = err; s[0] = runt | lng | err;
        return s;
    endfunction

    function automatic bit exp_drop(input int len, input bit err, input bit fr, input bit fe);
        return (len < 64 && !fr) || (err && !fe);
    endfunction

    task automatic send(input int len, input int err_at);
        int hits = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            while (!rx_ready) @(negedge clk);
            if (mem_req) hits++;
            rx_valid = 1'b1; rx_data = frame_b[i];
            rx_last = (i == len - 1); rx_err = (i == err_at);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
        chk("R11 ready after last", {31'b0, rx_ready}, 32'h0);
        while (!rx_ready) @(negedge clk);
        chk("R2 memory idle during frame", hits, 0);
    endtask

    task automatic fill(input int len);
        for (int i = 0; i < len; i++) frame_b[i] = 8'($urandom);
    endtask

    task automatic check_data(input string tag, input int k, input int len);
        int n = (len < SIZE) ? len : SIZE;
        int bad = 0;
        int bw = (BUFB + k*256) / 4;
        for (int i = 0; i < n; i++)
            if (tb_mem[bw + i/4][(i%4)*8 +: 8] !== frame_b[i]) bad++;
        chk(tag, bad, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int dummy;
        dummy = $urandom(1234);
        for (int i = 0; i < 1024; i++) tb_mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", {31'b0, rx_ready}, 0);
        chk("R1 reset mem_req", {31'b0, mem_req}, 0);
        chk("R1 reset ovf", {16'b0, ovf_count}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < NDESC; k++) arm(k, 1'b1);
        @(negedge clk);
        chk("R1 idle before start", {31'b0, rx_ready}, 0);
        cfg_base = 32'h0; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        @(negedge clk);
        chk("R2 ready after start", {31'b0, rx_ready}, 1);

        // Clean frame into descriptor 0.
        fill(100); send(100, -1);
        chk("R4 clean status", tb_mem[0], 32'd100 << 16);
        check_data("R3 clean data", 0, 100);

        // Runt dropped, then 64-byte frame lands in descriptor 1.
        fill(20); send(20, -1);
        chk("R5 runt dropped", tb_mem[4], 32'h8000_0000);
        fill(64); send(64, -1);
        chk("R5 64 bytes kept", tb_mem[4], 32'd64 << 16);
        check_data("R9 advanced to desc 1", 1, 64);

        // Forwarded runt into descriptor 2.
        cfg_fwd_runt = 1'b1;
        fill(63); send(63, -1);
        chk("R6 runt forwarded", tb_mem[8], exp_status(63, 1'b0, SIZE));
        check_data("R6 runt data", 2, 63);
        cfg_fwd_runt = 1'b0;

        // Error frame dropped, then forwarded into descriptor 3.
        fill(80); send(80, 40);
        chk("R7 error dropped", tb_mem[12], 32'h8000_0000);
        cfg_fwd_err = 1'b1;
        fill(80); send(80, 40);
        chk("R7 error forwarded", tb_mem[12], exp_status(80, 1'b1, SIZE));
        cfg_fwd_err = 1'b0;

        // Wrap to descriptor 0 with an over-long frame.
        arm(0, 1'b1);
        wr(BUFB/4 + 50, 32'hDEAD_BEEF);
        fill(220); send(220, -1);
        chk("R8 too long status", tb_mem[0], exp_status(220, 1'b0, SIZE));
        check_data("R9 wrapped data", 0, 220);
        chk("R8 word past size untouched", tb_mem[BUFB/4 + 50], 32'hDEAD_BEEF);

        // Descriptor 1 is still released from its earlier use: overflow.
        fill(90); send(90, -1);
        chk("R10 overflow counted", {16'b0, ovf_count}, 1);
        chk("R10 descriptor untouched", tb_mem[4], 32'd64 << 16);
        arm(1, 1'b1);
        fill(90); send(90, -1);
        chk("R10 same descriptor reused", tb_mem[4], 32'd90 << 16);
        chk("R10 count steady", {16'b0, ovf_count}, 1);
        cur = 2;

        // Random frames against the bench model.
        for (int n = 0; n < 150; n++) begin
            int len = 1 + int'($urandom % 230);
            bit e  = ($urandom % 4) == 0;
            int ep = e ? int'($urandom % len) : -1;
            bit fr = $urandom % 2;
            bit fe = $urandom % 2;
            arm(cur, 1'b1);
            fill(len);
            cfg_fwd_runt = fr; cfg_fwd_err = fe;
            send(len, ep);
            if (exp_drop(len, e, fr, fe)) begin
                if (e && !fe) chk("R7 random drop", tb_mem[cur*4], 32'h8000_0000);
                else          chk("R5 random drop", tb_mem[cur*4], 32'h8000_0000);
            end else begin
                chk("R4 random status", tb_mem[cur*4], exp_status(len, e, SIZE));
                check_data("R3 random data", cur, len);
                cur = (cur + 1) % NDESC;
            end
        end
        chk("R10 no spurious overflow", {16'b0, ovf_count}, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule